// File: doc/BRIEF.md
# Compare-Reload Periodic Waveform Timer

This block is one timer channel that turns a module clock into a periodic rectangular wave. A 16-bit up-counter advances on count ticks. A tick comes either from a power-of-two prescaler on the module clock or from rising edges on a cascade input. That input is normally the raw flag of another channel, so two channels can be chained to reach longer periods. The period is set by a load register. When the counter matches the second compare register, it is reloaded from the load register instead of running on. The output flag is set when the counter matches the first compare register and cleared when it matches the second.

Software programs four words through a simple write port: compare 1, compare 2, the load value and a control word. The control word selects the count source, starts or stops the channel, inverts the output, gates the output pin, and chooses between reload and free-running counting. With compare 2 at 0xFFFF and the load value at 0x10000 − range, the wave repeats every `range` ticks. Compare 1 at 0xFFFF − k gives a high time of k ticks, so k = range·d/1000 gives a duty of d per thousand.

Top module: `cmrt_timer`

## Requirements
- R1: Reset (asynchronous, active low) clears all four registers, the counter and the flag. While reset is held and afterwards with no write, `flag_out` and `wave_out` are 0.
- R2: The control field src (control bits [4:0]) chooses the count source. Codes 24, 25, 26, 27, 28, 29, 30 and 31 give one tick every 1, 2, 4, 8, 16, 32, 64 and 128 module clocks. Code 16 selects the cascade input. Every other code gives no ticks at all.
- R3: Writing the control word (address 3) with the run bit (bit 5) set while the channel is stopped loads the counter from the load register (address 2) at that edge and restarts the prescaler. With the prescaler at divide 1, the first tick is on the next edge.
- R4: With the reload bit (control bit 8) set, a tick taken while the counter equals compare 2 (address 1) reloads the counter from the load register. With compare 2 = 0xFFFF and load = 0x10000 − range, the output period is range ticks.
- R5: With the reload bit clear, the counter wraps from 0xFFFF to 0, giving a period of 65536 ticks whatever the load value.
- R6: A tick taken while the counter equals compare 1 (address 0) sets the flag. A tick taken while it equals compare 2 clears it. When both match on the same tick, the clear wins.
- R7: With compare 2 = 0xFFFF and compare 1 = 0xFFFF − k, the flag is high for k ticks of each period.
- R8: The invert bit (control bit 6) inverts the flag on its way to `wave_out`.
- R9: With the output-enable bit (control bit 7) clear, `wave_out` stays 0 while `flag_out` keeps running.
- R10: With the cascade source selected, each rising edge of `cascade_in` is exactly one tick. A level held high for many cycles counts once.
- R11: With the run bit clear, the counter and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare 1, 1 compare 2, 2 load, 3 control |
| wr_data | input | 16 | Write data (control uses bits [8:0]) |
| cascade_in | input | 1 | External count source, synchronous to clk |
| flag_out | output | 1 | Raw output flag, for cascading into another channel |
| wave_out | output | 1 | Waveform pin after polarity and enable |

## Verification
The main wave is driven from a table of settings that pairs different prescaler codes with different ranges and duty values. From its first rising edge, the bench measures the high time and the period in clock cycles. This separates an error in the divider from an error in the reload value or in the compare-1 position. Directed cases cover what the table cannot reach. These are the exact tick on which a started counter first sets the flag, equal compares where the clear must win, and the wrap period of free-running mode. The cascade case holds `cascade_in` high for many cycles to tell edge counting from level counting. Inversion, output gating, a stopped channel and an unassigned source code are each observed at the pins.

// File: rtl/cmrt_pkg.sv
package cmrt_pkg;
  localparam int CNT_W        = 16;
  localparam int PSC_STAGES   = 8;
  localparam int SRC_W        = 5;
  localparam int SRC_PSC_BASE = 24;
  localparam int SRC_CASCADE  = 16;

  typedef enum logic [1:0] {
    REG_CMP1 = 2'd0,
    REG_CMP2 = 2'd1,
    REG_LOAD = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             reload;
    logic             oe;
    logic             invert;
    logic             run;
    logic [SRC_W-1:0] src;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmrt_prescale.sv
module cmrt_prescale #(
  parameter int STAGES   = 8,
  parameter int SEL_BITS = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                run,
  input  logic [SEL_BITS-1:0] sel,
  output logic                tick
);
  localparam int CW = (STAGES > 1) ? STAGES - 1 : 1;

  logic [CW-1:0]     div_q;
  logic [CW-1:0]     div_d;
  logic [STAGES-1:0] stage_tick;

  // Stage i ticks once every 2**i clocks: when the low i bits are all ones.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam logic [CW-1:0] MASK = CW'((1 << i) - 1);
    assign stage_tick[i] = ((div_q & MASK) == MASK);
  end

  assign tick = stage_tick[sel];

  always_comb begin
    div_d = div_q;
    if (clr)      div_d = '0;
    else if (run) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cmrt_edge.sv
module cmrt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  assign rise = sig & ~sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end
endmodule

// File: rtl/cmrt_core.sv
module cmrt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic         reload_en,
  input  logic [W-1:0] cmp1,
  input  logic [W-1:0] cmp2,
  input  logic [W-1:0] load,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_d;
  logic         flag_d;
  logic         hit1;
  logic         hit2;

  assign hit1 = (cnt == cmp1);
  assign hit2 = (cnt == cmp2);

  always_comb begin
    cnt_d  = cnt;
    flag_d = flag;
    if (start) begin
      cnt_d = load;
    end else if (tick) begin
      if (hit1) flag_d = 1'b1;
      if (hit2) flag_d = 1'b0;          // clear has priority over set
      cnt_d = (reload_en && hit2) ? load : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/cmrt_timer.sv
module cmrt_timer
  import cmrt_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int STAGES = PSC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         cascade_in,
  output logic         flag_out,
  output logic         wave_out
);
  localparam int SEL_BITS = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [SRC_W-1:0] PSC_LO = SRC_W'(SRC_PSC_BASE);
  localparam logic [SRC_W-1:0] PSC_HI = SRC_W'(SRC_PSC_BASE + STAGES - 1);
  localparam logic [SRC_W-1:0] CASC   = SRC_W'(SRC_CASCADE);

  logic [W-1:0] cmp1_q, cmp1_d;
  logic [W-1:0] cmp2_q, cmp2_d;
  logic [W-1:0] load_q, load_d;
  ctrl_t        ctrl_q, ctrl_d;
  ctrl_t        wr_ctrl;

  logic                start;
  logic                src_psc;
  logic                src_casc;
  logic [SEL_BITS-1:0] psc_sel;
  logic                psc_tick;
  logic                casc_rise;
  logic                cnt_tick;
  logic [W-1:0]        cnt_w;
  logic                flag_w;

  assign wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign start   = wr_en && (wr_addr == REG_CTRL) && wr_ctrl.run && !ctrl_q.run;

  // register write port: next state
  always_comb begin
    cmp1_d = cmp1_q;
    cmp2_d = cmp2_q;
    load_d = load_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_addr)
        REG_CMP1: cmp1_d = wr_data;
        REG_CMP2: cmp2_d = wr_data;
        REG_LOAD: load_d = wr_data;
        default:  ctrl_d = wr_ctrl;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp1_q <= '0;
      cmp2_q <= '0;
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      cmp1_q <= cmp1_d;
      cmp2_q <= cmp2_d;
      load_q <= load_d;
      ctrl_q <= ctrl_d;
    end
  end

  // count source selection
  assign src_psc  = (ctrl_q.src >= PSC_LO) && (ctrl_q.src <= PSC_HI);
  assign src_casc = (ctrl_q.src == CASC);
  assign psc_sel  = SEL_BITS'(ctrl_q.src - PSC_LO);

  cmrt_prescale #(.STAGES(STAGES), .SEL_BITS(SEL_BITS)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .run   (ctrl_q.run),
    .sel   (psc_sel),
    .tick  (psc_tick)
  );

  cmrt_edge u_casc (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (cascade_in),
    .rise  (casc_rise)
  );

  always_comb begin
    cnt_tick = 1'b0;
    if (ctrl_q.run) begin
      if (src_psc)       cnt_tick = psc_tick;
      else if (src_casc) cnt_tick = casc_rise;
    end
  end

  cmrt_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (cnt_tick),
    .reload_en (ctrl_q.reload),
    .cmp1      (cmp1_q),
    .cmp2      (cmp2_q),
    .load      (load_q),
    .cnt       (cnt_w),
    .flag      (flag_w)
  );

  assign flag_out = flag_w;
  assign wave_out = ctrl_q.oe & (flag_w ^ ctrl_q.invert);
endmodule

// File: rtl/cmrt_checker.sv
module cmrt_checker
  import cmrt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         tick,
  input ctrl_t        ctrl,
  input logic [W-1:0] cmp1,
  input logic [W-1:0] cmp2,
  input logic [W-1:0] load,
  input logic [W-1:0] cnt,
  input logic         flag,
  input logic         wave
);
  localparam logic [SRC_W-1:0] PSC_LO = SRC_W'(SRC_PSC_BASE);
  localparam logic [SRC_W-1:0] PSC_HI = SRC_W'(SRC_PSC_BASE + PSC_STAGES - 1);
  localparam logic [SRC_W-1:0] CASC   = SRC_W'(SRC_CASCADE);

  p_idle_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src != CASC && (ctrl.src < PSC_LO || ctrl.src > PSC_HI)) |-> !tick);

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(load)));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && ctrl.reload && cnt == cmp2) |=> (cnt == $past(load)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && !ctrl.reload && cnt == {W{1'b1}}) |=> (cnt == '0));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && cnt == cmp1 && cnt != cmp2));

  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(tick && cnt == cmp2));

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.oe |-> !wave);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !start) |=> ($stable(cnt) && $stable(flag)));
endmodule

bind cmrt_timer cmrt_checker #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .tick  (cnt_tick),
  .ctrl  (ctrl_q),
  .cmp1  (cmp1_q),
  .cmp2  (cmp2_q),
  .load  (load_q),
  .cnt   (cnt_w),
  .flag  (flag_w),
  .wave  (wave_out)
);

// File: tb/cmrt_timer_tb.sv
module cmrt_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        cascade_in;
  logic        flag_out;
  logic        wave_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmrt_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cascade_in (cascade_in),
    .flag_out   (flag_out),
    .wave_out   (wave_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector table: {src code, range in ticks, high ticks k, divide ratio}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{24,  10,  3,   1},
    '{26,  20, 10,   4},
    '{31,   8,  2, 128},
    '{25, 100,  1,   2},
    '{27,  16, 12,   8}
  };

  function automatic logic [15:0] ctrl_word(input int src, input bit run, input bit inv,
                                            input bit oe, input bit reload);
    return {7'd0, reload, oe, inv, run, 5'(src)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int c1, input int c2, input int ld);
    wr(2'd0, 16'(c1));
    wr(2'd1, 16'(c2));
    wr(2'd2, 16'(ld));
  endtask

  // time at level lvl, then full period, both in clock cycles
  task automatic measure(input logic lvl, input int limit, output int active, output int period);
    int n;
    active = -1; period = -1;
    n = 0;
    while (wave_out === lvl && n < limit) begin @(negedge clk); n++; end
    n = 0;
    while (wave_out !== lvl && n < limit) begin @(negedge clk); n++; end
    if (n >= limit) return;
    active = 0;
    while (wave_out === lvl && active < limit) begin @(negedge clk); active++; end
    period = active;
    while (wave_out !== lvl && period < limit) begin @(negedge clk); period++; end
  endtask

  task automatic casc_pulse(input int hold);
    @(negedge clk); cascade_in = 1'b1;
    repeat (hold) @(negedge clk);
    cascade_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, per, n, cnt_a, cnt_b;
    logic f0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cascade_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset wave", int'(wave_out), 0);
    check("R1 reset flag", int'(flag_out), 0);
    rst_n = 1'b1;

    // table walk: R2 divider, R4 period, R7 duty
    for (int v = 0; v < NV; v++) begin
      wr(2'd3, 16'd0);
      setup(65535 - VEC[v][2], 65535, 65536 - VEC[v][1]);
      wr(2'd3, ctrl_word(VEC[v][0], 1, 0, 1, 1));
      measure(1'b1, 5000, hi, per);
      check($sformatf("R7 high time vec%0d", v), hi, VEC[v][2] * VEC[v][3]);
      check($sformatf("R2 R4 period vec%0d", v), per, VEC[v][1] * VEC[v][3]);
    end

    // R3: counter starts at load; cmp1 = load+3 -> flag set on 4th edge
    do_reset();
    setup(16'h1003, 16'hFFFF, 16'h1000);
    wr(2'd3, ctrl_word(24, 1, 0, 1, 1));
    n = 0;
    while (!flag_out && n < 100) begin @(negedge clk); n++; end
    check("R3 first set after start", n, 4);

    // R8: inverted output, low time = k
    wr(2'd3, 16'd0);
    setup(65535 - 6, 65535, 65536 - 20);
    wr(2'd3, ctrl_word(24, 1, 1, 1, 1));
    measure(1'b0, 5000, hi, per);
    check("R8 inverted low time", hi, 6);
    check("R8 inverted period", per, 20);

    // R9: output disabled
    wr(2'd3, 16'd0);
    setup(65535 - 3, 65535, 65536 - 10);
    wr(2'd3, ctrl_word(24, 1, 0, 0, 1));
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wave_out) cnt_a++;
      if (flag_out) cnt_b++;
    end
    check("R9 pin held low", cnt_a, 0);
    check("R9 flag still runs", int'(cnt_b > 0), 1);

    // R6: equal compares, clear wins
    do_reset();
    setup(16'hFFF8, 16'hFFF8, 16'hFFF0);
    wr(2'd3, ctrl_word(24, 1, 0, 1, 1));
    cnt_a = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (flag_out) cnt_a++; end
    check("R6 clear wins over set", cnt_a, 0);

    // R2: unassigned source code gives no ticks
    do_reset();
    setup(16'hFFF6, 16'hFFFF, 16'hFFF6);
    wr(2'd3, ctrl_word(5, 1, 0, 1, 1));
    cnt_a = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (flag_out) cnt_a++; end
    check("R2 idle source", cnt_a, 0);

    // R10: cascade edges; cmp1 = load+1, cmp2 = load+3
    do_reset();
    setup(16'hFFFD, 16'hFFFF, 16'hFFFC);
    wr(2'd3, ctrl_word(16, 1, 0, 1, 1));
    casc_pulse(3);
    casc_pulse(3);
    check("R10 set after second edge", int'(flag_out), 1);
    casc_pulse(40);
    check("R10 long high counts once", int'(flag_out), 1);
    casc_pulse(1);
    check("R10 clear after fourth edge", int'(flag_out), 0);

    // R11: stopped channel holds the flag
    wr(2'd3, 16'd0);
    setup(65535 - 10, 65535, 65536 - 20);
    wr(2'd3, ctrl_word(26, 1, 0, 1, 1));
    repeat (37) @(negedge clk);
    wr(2'd3, ctrl_word(26, 0, 0, 1, 1));
    f0 = flag_out; cnt_a = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (flag_out !== f0) cnt_a++; end
    check("R11 flag holds while stopped", cnt_a, 0);

    // R1: reset in mid-run
    wr(2'd3, ctrl_word(24, 1, 1, 1, 1));
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 wave during reset", int'(wave_out), 0);
    rst_n = 1'b1;
    cnt_a = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (flag_out || wave_out) cnt_a++; end
    check("R1 quiet after reset", cnt_a, 0);

    // R5: free-running wrap, load ignored for period
    setup(65535 - 5, 65535, 16'hFFF0);
    wr(2'd3, ctrl_word(24, 1, 0, 1, 0));
    measure(1'b1, 70000, hi, per);
    check("R5 free-run high time", hi, 5);
    check("R5 free-run period", per, 65536);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule